// File: doc/BRIEF.md
# LED Breathing PWM Controller

This block drives a single LED from an 8-bit pulse-width modulator. The duty cycle moves up and down between a lower and an upper bound, so the LED appears to breathe. Software sets the bounds, the step sizes, the update interval and the mode through a small word-addressed register port. Each register write carries byte strobes.

At a period boundary the duty value may be moved by a step. The step is taken from one of eight 4-bit fields, and a segment index picks the field. In symmetric mode the index comes from the top three duty bits. In asymmetric mode the index is the ramp direction followed by the top two duty bits, so rising and falling ramps can have different shapes. The bounds are double-buffered. A write lands in a holding copy, and the active bounds take that value only at a period boundary.

Top module: `led_breath`

## Requirements
- R1: When enabled, the period counter runs through 256 clocks per period, and `led_out` is high for exactly `duty_out` clocks of each period. When disabled, `led_out` is low and the counter restarts from zero on the next enable.
- R2: Word 0 is the mode word. Bit 0 enables the block. Bit 1 selects symmetric mode when 1 and asymmetric mode when 0.
- R3: Word 2 holds eight 4-bit step fields. Segment k occupies bits [4k+3:4k], and the word reads back as written.
- R4: In symmetric mode the segment index is `duty_out[7:5]`.
- R5: In asymmetric mode the segment index is {`ramp_down`, `duty_out[7:6]`}.
- R6: On an adjustment, a rising duty gains the step. If the result reaches or passes the upper bound, the duty becomes that bound and `ramp_down` goes to 1. A falling duty loses the step. If the result reaches or goes below the lower bound, the duty becomes that bound and `ramp_down` goes to 0. The result is always kept within the bounds, and a zero step leaves the duty unchanged.
- R7: Word 3 bits [7:0] hold N. The duty is adjusted once every N+1 periods, so N=0 means every period.
- R8: Word 1 holds the bounds: bits [7:0] are the lower bound and bits [15:8] are the upper bound. Writes go to the holding copy. Strobe 0 loads only the lower byte and strobe 1 loads only the upper byte.
- R9: While enabled, the holding bounds become active only at the end of a period, and an adjustment made at that boundary uses them. While disabled, the active bounds follow the holding copy one clock later.
- R10: Reading word 1 returns the active bounds, not the holding copy. `bus_rdata` is registered and reflects `bus_sel` from the previous clock.
- R11: After reset: duty 0, rising, LED low, bounds lower 0 and upper 255, mode, step and interval words all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_be | input | 4 | Byte strobes for the write |
| bus_sel | input | 2 | Word select (0 mode, 1 bounds, 2 steps, 3 interval) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_out | output | 1 | PWM output |
| duty_out | output | 8 | Current duty value |
| ramp_down | output | 1 | 1 while the ramp is falling |

## Verification
Long ramps in each mode are scored against an independently computed duty sequence, so a wrong index formation, a missing clamp, or a turn that is late by one step shows up as a mismatched value or direction. The spacing between duty changes is measured. An interval counter that is off by one would give spacings of 512 or 1024 clocks instead of 768. The bounds are rewritten in the middle of a period and read back at once, which catches a design that exposes the holding copy or commits it early. Single-byte strobe writes catch a design that clobbers the neighbouring bound. A zero-step run checks that the duty holds still and that the LED high time per period equals the duty, which exposes an off-by-one compare in the modulator.

// File: rtl/led_breath_pkg.sv
package led_breath_pkg;
  localparam int DUTY_W     = 8;
  localparam int SEG_N      = 8;
  localparam int STEP_W     = 4;
  localparam int STEP_VEC_W = SEG_N * STEP_W;
  localparam int IVL_W      = 8;
  localparam int BUS_W      = 32;

  typedef struct packed {
    logic [DUTY_W-1:0] hi;
    logic [DUTY_W-1:0] lo;
  } bounds_t;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_BND   = 2'd1,
    SEL_STEP  = 2'd2,
    SEL_IVL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/led_breath_regs.sv
module led_breath_regs
  import led_breath_pkg::*;
#(
  parameter int BW  = BUS_W,
  parameter int SVW = STEP_VEC_W,
  parameter int IW  = IVL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wen,
  input  logic [BW/8-1:0] be,
  input  logic [1:0]      sel,
  input  logic [BW-1:0]   wdata,
  input  logic            period_end,
  output logic [BW-1:0]   rdata,
  output logic            en,
  output logic            sym,
  output logic [SVW-1:0]  step_vec,
  output logic [IW-1:0]   ival,
  output bounds_t         hold,
  output bounds_t         act
);
  localparam int NBYTE = SVW / 8;

  // mode, interval and bound staging
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      sym  <= 1'b0;
      ival <= '0;
      hold <= '{hi: '1, lo: '0};
    end else if (wen) begin
      case (reg_sel_e'(sel))
        SEL_MODE: if (be[0]) {sym, en} <= wdata[1:0];
        SEL_BND: begin
          if (be[0]) hold.lo <= wdata[DUTY_W-1:0];
          if (be[1]) hold.hi <= wdata[2*DUTY_W-1:DUTY_W];
        end
        SEL_IVL:  if (be[0]) ival <= wdata[IW-1:0];
        default: ;
      endcase
    end
  end

  // step word, one lane per byte strobe
  for (genvar b = 0; b < NBYTE; b++) begin : g_step_lane
    always_ff @(posedge clk) begin
      if (rst)
        step_vec[8*b +: 8] <= '0;
      else if (wen && reg_sel_e'(sel) == SEL_STEP && be[b])
        step_vec[8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  // active bounds: commit at a boundary, or follow while idle
  always_ff @(posedge clk) begin
    if (rst)
      act <= '{hi: '1, lo: '0};
    else if (!en || period_end)
      act <= hold;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (reg_sel_e'(sel))
        SEL_MODE: rdata <= {{(BW-2){1'b0}}, sym, en};
        SEL_BND:  rdata <= {{(BW-2*DUTY_W){1'b0}}, act.hi, act.lo};
        SEL_STEP: rdata <= step_vec;
        default:  rdata <= {{(BW-IW){1'b0}}, ival};
      endcase
    end
  end

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !period_end) |=> $stable(act));
endmodule

// File: rtl/led_breath_pwm.sv
module led_breath_pwm
  import led_breath_pkg::*;
#(
  parameter int DW = DUTY_W,
  parameter int IW = IVL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] duty,
  input  logic [IW-1:0] ival,
  output logic          period_end,
  output logic          adj,
  output logic          led
);
  logic [DW-1:0] cnt_q;
  logic [IW-1:0] ivl_q;

  assign period_end = en && (&cnt_q);
  assign adj        = period_end && (ivl_q >= ival);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      ivl_q <= '0;
      led   <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      led   <= (cnt_q < duty);
      if (period_end) ivl_q <= adj ? '0 : ivl_q + 1'b1;
    end
  end

  // R1
  led_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !led);
  // R1
  cnt_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> (cnt_q == '0));
endmodule

// File: rtl/led_breath_ramp.sv
module led_breath_ramp
  import led_breath_pkg::*;
#(
  parameter int DW  = DUTY_W,
  parameter int SN  = SEG_N,
  parameter int SW  = STEP_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adj,
  input  logic           sym,
  input  logic [SN*SW-1:0] step_vec,
  input  bounds_t        bnd,
  output logic [DW-1:0]  duty,
  output logic           falling
);
  localparam int IXW = $clog2(SN);

  logic [IXW-1:0] idx;
  logic [SW-1:0]  step;
  logic [DW:0]    step_x, up_sum, lo_plus;
  logic [DW-1:0]  dn_val, nxt;
  logic           nxt_fall;

  // R4 R5: two ways to form the segment index
  always_comb begin
    if (sym) idx = duty[DW-1 -: IXW];
    else     idx = {falling, duty[DW-1 -: IXW-1]};
  end

  assign step    = step_vec[idx*SW +: SW];
  assign step_x  = {{(DW+1-SW){1'b0}}, step};
  assign up_sum  = {1'b0, duty} + step_x;
  assign lo_plus = {1'b0, bnd.lo} + step_x;
  assign dn_val  = duty - step;

  always_comb begin
    nxt      = duty;
    nxt_fall = falling;
    if (!falling) begin
      if (up_sum >= {1'b0, bnd.hi}) begin
        nxt      = bnd.hi;
        nxt_fall = 1'b1;
      end else if (up_sum[DW-1:0] < bnd.lo) nxt = bnd.lo;
      else nxt = up_sum[DW-1:0];
    end else begin
      if ({1'b0, duty} <= lo_plus) begin
        nxt      = bnd.lo;
        nxt_fall = 1'b0;
      end else if (dn_val > bnd.hi) nxt = bnd.hi;
      else nxt = dn_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty    <= '0;
      falling <= 1'b0;
    end else if (adj) begin
      duty    <= nxt;
      falling <= nxt_fall;
    end
  end

  // R6
  duty_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (adj && bnd.lo <= bnd.hi) |=> (duty >= $past(bnd.lo) && duty <= $past(bnd.hi)));
  // R6
  duty_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !adj |=> ($stable(duty) && $stable(falling)));
endmodule

// File: rtl/led_breath.sv
module led_breath
  import led_breath_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wen,
  input  logic [BUS_W/8-1:0] bus_be,
  input  logic [1:0]       bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             led_out,
  output logic [DUTY_W-1:0] duty_out,
  output logic             ramp_down
);
  logic                  en, sym, period_end, adj;
  logic [STEP_VEC_W-1:0] step_vec;
  logic [IVL_W-1:0]      ival;
  bounds_t               hold, act;

  led_breath_regs #(.BW(BUS_W), .SVW(STEP_VEC_W), .IW(IVL_W)) u_regs (
    .clk(clk), .rst(rst), .wen(bus_wen), .be(bus_be), .sel(bus_sel),
    .wdata(bus_wdata), .period_end(period_end), .rdata(bus_rdata),
    .en(en), .sym(sym), .step_vec(step_vec), .ival(ival),
    .hold(hold), .act(act)
  );

  led_breath_pwm #(.DW(DUTY_W), .IW(IVL_W)) u_pwm (
    .clk(clk), .rst(rst), .en(en), .duty(duty_out), .ival(ival),
    .period_end(period_end), .adj(adj), .led(led_out)
  );

  // adjustments happen only at a boundary, where the holding copy is committed
  led_breath_ramp #(.DW(DUTY_W), .SN(SEG_N), .SW(STEP_W)) u_ramp (
    .clk(clk), .rst(rst), .adj(adj), .sym(sym), .step_vec(step_vec),
    .bnd(hold), .duty(duty_out), .falling(ramp_down)
  );
endmodule

// File: tb/led_breath_test.sv
module led_breath_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [1:0]  bus_sel = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        led_out;
  logic [7:0]  duty_out;
  logic        ramp_down;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  led_breath uut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_be(bus_be),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_out(led_out), .duty_out(duty_out), .ramp_down(ramp_down)
  );

  typedef struct { int duty; int fall; int gap; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = a; bus_be = be; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  // reference ramp step, built from R4 R5 R6
  function automatic void ref_step(inout int d, inout int f, input bit sym,
                                   input logic [31:0] st, input int lo, input int hi);
    int ix, s, n;
    ix = sym ? (d >> 5) : ((f << 2) | (d >> 6));
    s  = int'((st >> (4 * ix)) & 32'hF);
    if (f == 0) begin
      n = d + s;
      if (n >= hi) begin d = hi; f = 1; end
      else d = (n < lo) ? lo : n;
    end else begin
      if (d <= lo + s) begin d = lo; f = 0; end
      else begin n = d - s; d = (n > hi) ? hi : n; end
    end
  endfunction

  // monitor: pop an expected item on every duty change
  bit mon_on = 0;
  bit mon_first = 1;
  int cyc = 0;
  int last_cyc = 0;
  logic [7:0] prev_d = '0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on && duty_out !== prev_d) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 unexpected change", int'(duty_out), int'(prev_d));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(duty_out) == e.duty, "R4/R5/R6 duty", int'(duty_out), e.duty);
        chk(int'(ramp_down) == e.fall, "R6 direction", int'(ramp_down), e.fall);
        if (!mon_first)
          chk(cyc - last_cyc == e.gap, "R7 spacing", cyc - last_cyc, e.gap);
      end
      mon_first = 0;
      last_cyc = cyc;
    end
    prev_d = duty_out;
  end

  task automatic run_ramp(input int n, input int ivl, input bit sym,
                          input logic [31:0] st, input int lo, input int hi);
    int d, f, lim;
    wr(2'd2, 4'hF, st);
    wr(2'd3, 4'h1, ivl);
    wr(2'd1, 4'h3, {16'h0, hi[7:0], lo[7:0]});
    d = int'(duty_out);
    f = int'(ramp_down);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      ref_step(d, f, sym, st, lo, hi);
      e.duty = d; e.fall = f; e.gap = 256 * (ivl + 1);
      sb.push_back(e);
    end
    mon_first = 1;
    mon_on = 1;
    wr(2'd0, 4'h1, {30'h0, sym, 1'b1});
    lim = n * (ivl + 1) * 256 + 1000;
    while (sb.size() != 0 && lim > 0) begin
      @(negedge clk);
      lim--;
    end
    chk(sb.size() == 0, "R7 ramp finished", sb.size(), 0);
    sb.delete();
    wr(2'd0, 4'h1, 32'h0);
    mon_on = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int d0, hi_cnt;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    chk(duty_out == 8'd0, "R11 duty", duty_out, 0);
    chk(ramp_down == 1'b0, "R11 direction", ramp_down, 0);
    chk(led_out == 1'b0, "R11 led", led_out, 0);
    rd(2'd1, v); chk(v == 32'h0000FF00, "R11 bounds", v, 32'hFF00);
    rd(2'd0, v); chk(v == 32'h0, "R11 mode", v, 0);

    // R8 R9 R10: staging while idle, byte strobes
    wr(2'd1, 4'h3, 32'h0000_7828);
    rd(2'd1, v); chk(v == 32'h7828, "R9 idle follow", v, 32'h7828);
    wr(2'd1, 4'h2, 32'hFFFF_64FF);
    rd(2'd1, v); chk(v == 32'h6428, "R8 upper byte only", v, 32'h6428);
    wr(2'd1, 4'h1, 32'hFFFF_FF30);
    rd(2'd1, v); chk(v == 32'h6430, "R8 lower byte only", v, 32'h6430);
    wr(2'd1, 4'h3, 32'h0000_7828);

    // R3 step word readback, R2 mode readback
    wr(2'd2, 4'hF, 32'hFEDC_BA98);
    rd(2'd2, v); chk(v == 32'hFEDCBA98, "R3 step word", v, 32'hFEDCBA98);
    wr(2'd0, 4'h1, 32'h2);
    rd(2'd0, v); chk(v == 32'h2, "R2 mode word", v, 2);
    wr(2'd0, 4'h1, 32'h0);

    // R4 symmetric ramp
    run_ramp(20, 0, 1'b1, 32'hFEDC_BA98, 40, 120);
    // R5 asymmetric ramp with direction-dependent steps
    run_ramp(20, 0, 1'b0, 32'h5F3C_2749, 30, 150);
    // R7 interval of three periods
    run_ramp(4, 2, 1'b1, 32'h7777_7777, 30, 150);

    // R9 R10 staging while enabled
    wr(2'd1, 4'h3, 32'h0000_7828);
    wr(2'd3, 4'h1, 32'd255);
    wr(2'd0, 4'h1, 32'h3);
    repeat (20) @(negedge clk);
    wr(2'd1, 4'h3, 32'h0000_7030);
    rd(2'd1, v); chk(v == 32'h7828, "R10 reads active not holding", v, 32'h7828);
    repeat (300) @(negedge clk);
    rd(2'd1, v); chk(v == 32'h7030, "R9 commit at boundary", v, 32'h7030);
    wr(2'd0, 4'h1, 32'h0);

    // R6 zero step holds duty, R1 LED high time
    wr(2'd1, 4'h3, 32'h0000_FF00);
    wr(2'd2, 4'hF, 32'h0);
    wr(2'd3, 4'h1, 32'h0);
    d0 = int'(duty_out);
    wr(2'd0, 4'h1, 32'h1);
    repeat (1000) @(negedge clk);
    chk(int'(duty_out) == d0, "R6 zero step", duty_out, d0);
    hi_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (led_out) hi_cnt++;
    end
    chk(hi_cnt == d0, "R1 high time", hi_cnt, d0);
    wr(2'd0, 4'h1, 32'h0);
    repeat (2) @(negedge clk);
    chk(led_out == 1'b0, "R1 idle led", led_out, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule